// File: doc/BRIEF.md
# Bit-Parallel Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter built on distributed arithmetic with every data bit handled at once, so it takes one new sample on every clock. The stored samples, optionally folded in pairs when the coefficients are mirrored, form a set of DA inputs. Bit k of every DA input addresses its own copy of the partial-sum lookup tables. Each table covers a group of four DA inputs. A table whose four coefficients are all zero is replaced by a constant zero when the design is built. The plane results are weighted by 2^k, with the top plane carrying negative weight because the data is two's complement. They are then reduced by a shift-and-add tree that has a register at every level.

The full-precision sum can be rounded or truncated by dropping low bits, and it saturates to the output width. A sample-valid flag travels through the pipeline with the data. Two cascade outputs let several instances form one longer filter. The first carries the oldest stored sample. The second carries the core's unrounded partial sum, which the next core adds through its cascade input. Coefficients, data width, coefficient width, tap count, symmetry mode, output width and rounding are all elaboration-time parameters.

Top module: `pda_fir`

## Requirements
- R1: Each sample taken with `din_vld` high yields exactly one `dout_vld` pulse, LATENCY = 4 + ceil(log2(P)) clocks later. P is DW in plain mode and DW+1 in the two mirrored modes. A new sample may be taken on every clock.
- R2: In plain mode (COEF_PLAIN) the full sum is sum over i of COEFS[i]·x[n-i], for i from 0 to TAPS-1. Here x[n] is the newest sample, samples older than reset count as zero, and data and coefficients are signed two's complement.
- R3: In mirror mode (COEF_MIRROR) COEFS[i] weights both tap i and tap TAPS-1-i, for i < ceil(TAPS/2). When TAPS is odd, the middle tap is weighted once.
- R4: In anti-mirror mode (COEF_ANTIMIRROR) tap i is weighted by COEFS[i] and tap TAPS-1-i by -COEFS[i]. When TAPS is odd, the middle tap is weighted once by its coefficient.
- R5: While `din_vld` is low no sample is taken. The stored samples, and therefore `casc_dout`, hold their values.
- R6: `casc_dout` shows the oldest stored sample, x[n-TAPS+1]. A core fed from it with the same `din_vld` extends the delay line seamlessly.
- R7: `casc_psum_out` equals this core's full-precision sum plus `casc_psum_in`, both for the same sample. A chain of cores with equal latency yields, at the last core, the filter of the combined length with the same LATENCY.
- R8: The output takes the full sum, adds 2^(DROP-1) when ROUND=1 and DROP>0, and then shifts right arithmetically by DROP bits. With ROUND=0 the result is floor(sum / 2^DROP).
- R9: The scaled result saturates to the signed OW-bit range [-2^(OW-1), 2^(OW-1)-1].
- R10: During and right after reset, `dout`, `dout_vld`, `casc_dout` and `casc_psum_out` (with a zero cascade input) are all zero.
- R11: A four-input coefficient group whose coefficients are all zero contributes nothing. Its lookup tables are omitted without changing any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din_vld | input | 1 | Sample strobe: take `din` on this edge |
| din | input | DW | Signed input sample |
| casc_psum_in | input | FW | Signed partial sum from an upstream core (tie to zero when unused) |
| dout | output | OW | Rounded, saturated filter output |
| dout_vld | output | 1 | `dout` belongs to a sample taken LATENCY clocks earlier |
| casc_dout | output | DW | Oldest stored sample, for the next core's `din` |
| casc_psum_out | output | FW | Full-precision sum plus `casc_psum_in`, for the next core |

FW = CW + P + ceil(log2(K)) + 3, where K is the number of DA inputs: TAPS in plain mode, ceil(TAPS/2) otherwise.

## Verification
A wrong coefficient, a wrong pairing of taps or a wrong plane weight gives a mismatched `dout` value. It shows on the first valid output LATENCY clocks after a sample that exercises that tap or bit. Full-scale bursts of +127 and -128 make an error in the sign of the top plane, or in saturation, visible within one filter length. A tap line that moves without `din_vld`, or a valid flag travelling at the wrong depth, shows up on the very next clock: `casc_dout` differs from the oldest consumed sample, or `dout_vld` rises in the wrong cycle. Running two cores as a chain against one reference filter of twice the length catches any skew between the cascade sample path and the partial-sum path at the first output after the pipeline fills.

// File: rtl/pda_fir_pkg.sv
package pda_fir_pkg;

    typedef enum logic [1:0] {
        COEF_PLAIN      = 2'd0,
        COEF_MIRROR     = 2'd1,
        COEF_ANTIMIRROR = 2'd2
    } coef_mode_e;

    // number of DA inputs after optional pair folding
    function automatic int da_inputs(input coef_mode_e mode, input int taps);
        return (mode == COEF_PLAIN) ? taps : (taps + 1) / 2;
    endfunction

    // width of one DA input (folding adds one bit)
    function automatic int da_width(input coef_mode_e mode, input int dw);
        return (mode == COEF_PLAIN) ? dw : dw + 1;
    endfunction

endpackage

// File: rtl/pda_tapline.sv
module pda_tapline #(
    parameter int DW   = 8,
    parameter int TAPS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [TAPS],
    output logic signed [DW-1:0] casc_dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) taps[i] <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
        end
    end

    assign casc_dout = taps[TAPS-1];

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(casc_dout));

    // R6
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (casc_dout == $past(taps[TAPS-2])));

endmodule

// File: rtl/pda_preadd.sv
module pda_preadd
    import pda_fir_pkg::*;
#(
    parameter int         DW   = 8,
    parameter int         TAPS = 8,
    parameter coef_mode_e MODE = COEF_PLAIN,
    parameter int         K    = 8,
    parameter int         UW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] taps [TAPS],
    output logic signed [UW-1:0] u_q  [K]
);

    logic signed [UW-1:0] u_d [K];

    for (genvar i = 0; i < K; i++) begin : g_fold
        if (MODE == COEF_PLAIN) begin : g_plain
            assign u_d[i] = UW'(taps[i]);
        end else if (2 * i + 1 == TAPS) begin : g_mid
            assign u_d[i] = UW'(taps[i]);
        end else if (MODE == COEF_MIRROR) begin : g_sum
            assign u_d[i] = UW'(taps[i]) + UW'(taps[TAPS-1-i]);
        end else begin : g_diff
            assign u_d[i] = UW'(taps[i]) - UW'(taps[TAPS-1-i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < K; i++) u_q[i] <= '0;
        end else begin
            for (int i = 0; i < K; i++) u_q[i] <= u_d[i];
        end
    end

endmodule

// File: rtl/pda_plane.sv
module pda_plane #(
    parameter int K  = 8,
    parameter int PW = 12,
    parameter int COEFS [20] = '{default: 0}
) (
    input  logic [K-1:0]         bits,
    output logic signed [PW-1:0] psum
);

    localparam int NG  = (K + 3) / 4;
    localparam int BPW = NG * 4;

    function automatic bit grp_used(input int g);
        for (int j = 0; j < 4; j++)
            if ((4 * g + j) < K && COEFS[4 * g + j] != 0) return 1'b1;
        return 1'b0;
    endfunction

    // contents of one 16-entry partial-sum table, addressed by four bits
    function automatic logic signed [PW-1:0] lut_entry(input logic [3:0] a, input int g);
        logic signed [PW-1:0] s;
        s = '0;
        for (int j = 0; j < 4; j++)
            if ((4 * g + j) < K && a[j]) s = s + PW'(COEFS[4 * g + j]);
        return s;
    endfunction

    logic [BPW-1:0]       bp;
    logic signed [PW-1:0] gs [NG];

    assign bp = BPW'(bits);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        if (grp_used(g)) begin : g_lut
            assign gs[g] = lut_entry(bp[4*g +: 4], g);
        end else begin : g_trim
            assign gs[g] = '0;
        end
    end

    always_comb begin
        psum = '0;
        for (int g = 0; g < NG; g++) psum = psum + gs[g];
    end

endmodule

// File: rtl/pda_addtree.sv
module pda_addtree #(
    parameter int FW = 22,
    parameter int NL = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [FW-1:0] leaves [NL],
    output logic signed [FW-1:0] root
);

    localparam int LV = $clog2(NL);
    localparam int NP = 1 << LV;

    for (genvar l = 0; l <= LV; l++) begin : g_lv
        localparam int NN = NP >> l;
        logic signed [FW-1:0] nd [NN];
        logic signed [FW-1:0] tot;

        always_comb begin
            tot = '0;
            for (int j = 0; j < NN; j++) tot = tot + nd[j];
        end

        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < NN; j++) begin : g_pad
                if (j < NL) begin : g_in
                    assign nd[j] = leaves[j];
                end else begin : g_zero
                    assign nd[j] = '0;
                end
            end
        end else begin : g_add
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int j = 0; j < NN; j++) nd[j] <= '0;
                end else begin
                    for (int j = 0; j < NN; j++)
                        nd[j] <= g_lv[l-1].nd[2*j] + g_lv[l-1].nd[2*j+1];
                end
            end

            // R2
            sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tot == $past(g_lv[l-1].tot));
        end
    end

    assign root = g_lv[LV].nd[0];

endmodule

// File: rtl/pda_fir.sv
module pda_fir
    import pda_fir_pkg::*;
#(
    parameter int         DW    = 8,
    parameter int         CW    = 8,
    parameter int         TAPS  = 8,
    parameter int         OW    = 16,
    parameter int         DROP  = 4,
    parameter bit         ROUND = 1'b1,
    parameter coef_mode_e MODE  = COEF_PLAIN,
    parameter int         COEFS [20] = '{0: 3, 1: -5, 2: 17, 3: 40, 4: 40, 5: 17, 6: -5, 7: 3, default: 0},
    localparam int K       = da_inputs(MODE, TAPS),
    localparam int UW      = da_width(MODE, DW),
    localparam int PW      = CW + $clog2(K) + 1,
    localparam int FW      = CW + UW + $clog2(K) + 3,
    localparam int LATENCY = 4 + $clog2(UW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din_vld,
    input  logic signed [DW-1:0] din,
    input  logic signed [FW-1:0] casc_psum_in,
    output logic signed [OW-1:0] dout,
    output logic                 dout_vld,
    output logic signed [DW-1:0] casc_dout,
    output logic signed [FW-1:0] casc_psum_out
);

    localparam int     FW1    = FW + 1;
    localparam longint OMAX   = (longint'(1) <<< (OW - 1)) - 1;
    localparam longint OMIN   = -OMAX - 1;
    localparam longint BIAS   = (ROUND && DROP > 0) ? (longint'(1) <<< (DROP - 1)) : 0;
    localparam longint HI_THR = (OMAX <<< DROP) - BIAS;
    localparam longint LO_THR = ((OMIN + 1) <<< DROP) - BIAS;

    logic signed [DW-1:0] taps  [TAPS];
    logic signed [UW-1:0] u_q   [K];
    logic [K-1:0]         pbits [UW];
    logic signed [PW-1:0] ps    [UW];
    logic signed [FW-1:0] p_q   [UW];
    logic signed [FW-1:0] root;
    logic signed [FW-1:0] acc_d, acc_q;
    logic signed [FW:0]   biased, shifted;
    logic [LATENCY:0]     vld_sr;

    pda_tapline #(.DW(DW), .TAPS(TAPS)) u_tapline (
        .clk(clk), .rst_n(rst_n), .shift_en(din_vld), .din(din),
        .taps(taps), .casc_dout(casc_dout)
    );

    pda_preadd #(.DW(DW), .TAPS(TAPS), .MODE(MODE), .K(K), .UW(UW)) u_preadd (
        .clk(clk), .rst_n(rst_n), .taps(taps), .u_q(u_q)
    );

    for (genvar k = 0; k < UW; k++) begin : g_plane
        localparam bit NEGW = (k == UW - 1);
        logic signed [FW-1:0] ext;

        for (genvar i = 0; i < K; i++) begin : g_bit
            assign pbits[k][i] = u_q[i][k];
        end

        pda_plane #(.K(K), .PW(PW), .COEFS(COEFS)) u_plane (
            .bits(pbits[k]), .psum(ps[k])
        );

        assign ext = FW'(ps[k]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    p_q[k] <= '0;
            else if (NEGW) p_q[k] <= -(ext <<< k);
            else           p_q[k] <= ext <<< k;
        end
    end

    pda_addtree #(.FW(FW), .NL(UW)) u_tree (
        .clk(clk), .rst_n(rst_n), .leaves(p_q), .root(root)
    );

    assign acc_d         = root + casc_psum_in;
    assign casc_psum_out = acc_d;

    always_comb begin
        biased  = FW1'(acc_q) + FW1'(BIAS);
        shifted = biased >>> DROP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            dout   <= '0;
            vld_sr <= '0;
        end else begin
            acc_q  <= acc_d;
            vld_sr <= {vld_sr[LATENCY-1:0], din_vld};
            if (shifted > FW1'(OMAX))      dout <= OW'(OMAX);
            else if (shifted < FW1'(OMIN)) dout <= OW'(OMIN);
            else                           dout <= shifted[OW-1:0];
        end
    end

    assign dout_vld = vld_sr[LATENCY];

    // R9
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(dout) == OMAX) |-> (longint'($past(acc_q)) >= HI_THR));

    // R9
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(dout) == OMIN) |-> (longint'($past(acc_q)) < LO_THR));

endmodule

// File: tb/test_pda_fir.sv
module test_pda_fir;
    import pda_fir_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FWB        = 22;
    localparam int QD         = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din_vld = 1'b0;
    logic signed [7:0] din = '0;

    logic signed [15:0]    a_dout;
    logic                  a_vld;
    logic signed [7:0]     a_cdout;
    logic signed [FWB-1:0] a_psum;
    logic signed [11:0]    b_dout;
    logic                  b_vld;
    logic signed [7:0]     b_cdout;
    logic signed [FWB-1:0] b_psum;
    logic signed [9:0]     s_dout;
    logic                  s_vld;
    logic signed [7:0]     s_cdout;
    logic signed [FWB-1:0] s_psum;
    logic signed [9:0]     n_dout;
    logic                  n_vld;
    logic signed [7:0]     n_cdout;
    logic signed [FWB-1:0] n_psum;

    always #(CLK_PERIOD/2) clk = ~clk;

    // upstream core of the chain: taps 0..7
    pda_fir #(.DW(8), .CW(8), .TAPS(8), .OW(16), .DROP(0), .ROUND(1'b0), .MODE(COEF_PLAIN),
              .COEFS('{0: 127, 1: -128, 2: 45, 3: -7, 4: 88, 5: 0, 6: -60, 7: 13, default: 0}))
    i_pda_fir_up (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din), .casc_psum_in('0),
        .dout(a_dout), .dout_vld(a_vld), .casc_dout(a_cdout), .casc_psum_out(a_psum)
    );

    // downstream core of the chain: taps 8..15, first group all zero
    pda_fir #(.DW(8), .CW(8), .TAPS(8), .OW(12), .DROP(4), .ROUND(1'b1), .MODE(COEF_PLAIN),
              .COEFS('{0: 0, 1: 0, 2: 0, 3: 0, 4: 19, 5: -33, 6: 101, 7: -128, default: 0}))
    i_pda_fir (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(a_cdout), .casc_psum_in(a_psum),
        .dout(b_dout), .dout_vld(b_vld), .casc_dout(b_cdout), .casc_psum_out(b_psum)
    );

    pda_fir #(.DW(8), .CW(8), .TAPS(7), .OW(10), .DROP(3), .ROUND(1'b1), .MODE(COEF_MIRROR),
              .COEFS('{0: -128, 1: 77, 2: -12, 3: 127, default: 0}))
    i_pda_fir_sym (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din), .casc_psum_in('0),
        .dout(s_dout), .dout_vld(s_vld), .casc_dout(s_cdout), .casc_psum_out(s_psum)
    );

    pda_fir #(.DW(8), .CW(8), .TAPS(6), .OW(10), .DROP(5), .ROUND(1'b0), .MODE(COEF_ANTIMIRROR),
              .COEFS('{0: 90, 1: -128, 2: 31, default: 0}))
    i_pda_fir_anti (
        .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din(din), .casc_psum_in('0),
        .dout(n_dout), .dout_vld(n_vld), .casc_dout(n_cdout), .casc_psum_out(n_psum)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int cnt = 0;
    int hist [QD];
    int cf [4][16];
    int ntap [4];
    int drp [4];
    int rnd [4];
    int owd [4];
    int lat [4];
    longint exp_v [4][QD];
    int exp_c [4][QD];
    int wr [4];
    int rd [4];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint fir_ref(input int d, input int n);
        longint s = 0;
        for (int i = 0; i < ntap[d]; i++)
            if (n - i >= 0) s += longint'(cf[d][i]) * longint'(hist[n - i]);
        return s;
    endfunction

    function automatic longint scale_ref(input longint y, input int drop, input int rd_on, input int ow);
        longint v = y;
        longint hi = (longint'(1) <<< (ow - 1)) - 1;
        longint lo = -hi - 1;
        if (drop > 0) v = (v + (rd_on != 0 ? (longint'(1) <<< (drop - 1)) : 0)) >>> drop;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    task automatic check_dut(input int d, input bit vld, input longint val, input string req);
        if (rd[d] < wr[d] && exp_c[d][rd[d]] == cyc) begin
            check(vld == 1'b1, "R1 valid", longint'(vld), 1);
            check(val == exp_v[d][rd[d]], req, val, exp_v[d][rd[d]]);
            rd[d]++;
        end else begin
            check(vld == 1'b0, "R1 no valid", longint'(vld), 0);
        end
    endtask

    task automatic check_all();
        longint ec = (cnt >= 8) ? longint'(hist[cnt - 8]) : 0;
        check(longint'(a_cdout) == ec, "R5 R6 cascade sample", longint'(a_cdout), ec);
        check_dut(0, a_vld, longint'(a_dout), "R2 plain");
        check_dut(1, b_vld, longint'(b_dout), "R7 R8 R9 R11 chain");
        check_dut(2, s_vld, longint'(s_dout), "R3 R8 mirror");
        check_dut(3, n_vld, longint'(n_dout), "R4 R8 anti-mirror");
    endtask

    task automatic step(input bit v, input int x);
        @(negedge clk);
        check_all();
        din_vld = v;
        din = 8'(x);
        if (v) begin
            hist[cnt] = x;
            for (int d = 0; d < 4; d++) begin
                exp_v[d][wr[d]] = scale_ref(fir_ref(d, cnt), drp[d], rnd[d], owd[d]);
                exp_c[d][wr[d]] = cyc + 1 + lat[d];
                wr[d]++;
            end
            cnt++;
        end
    endtask

    initial begin
        int cA [8] = '{127, -128, 45, -7, 88, 0, -60, 13};
        int cB [8] = '{0, 0, 0, 0, 19, -33, 101, -128};
        int cS [7] = '{-128, 77, -12, 127, -12, 77, -128};
        int cN [6] = '{90, -128, 31, -31, 128, -90};
        void'($urandom(32'd7311));
        for (int d = 0; d < 4; d++) begin
            wr[d] = 0;
            rd[d] = 0;
            for (int i = 0; i < 16; i++) cf[d][i] = 0;
        end
        for (int i = 0; i < 8; i++) begin
            cf[0][i] = cA[i];
            cf[1][i] = cA[i];
            cf[1][i + 8] = cB[i];
        end
        for (int i = 0; i < 7; i++) cf[2][i] = cS[i];
        for (int i = 0; i < 6; i++) cf[3][i] = cN[i];
        ntap = '{8, 16, 7, 6};
        drp  = '{0, 4, 3, 5};
        rnd  = '{0, 1, 1, 0};
        owd  = '{16, 12, 10, 10};
        // R1: latency 4 + ceil(log2(P)); P = 8 plain, 9 mirrored
        lat  = '{7, 7, 8, 8};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(a_dout == 0 && b_dout == 0 && s_dout == 0 && n_dout == 0, "R10 dout", 0, 0);
        check({a_vld, b_vld, s_vld, n_vld} == 4'b0, "R10 dout_vld", 0, 0);
        check(a_cdout == 0 && b_cdout == 0, "R10 casc_dout", longint'(a_cdout), 0);
        check(a_psum == 0, "R10 casc_psum_out", longint'(a_psum), 0);
        rst_n = 1'b1;

        // directed: full-scale bursts exercise the negative top plane and saturation (R9)
        for (int i = 0; i < 20; i++) step(1'b1, 127);
        for (int i = 0; i < 20; i++) step(1'b1, -128);
        for (int i = 0; i < 10; i++) step(1'b1, 0);
        for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? 127 : -128);
        // R5: gaps hold the delay line
        for (int i = 0; i < 12; i++) step(i % 3 == 0, 100 - 17 * i);
        for (int i = 0; i < 10; i++) step(1'b0, 55);
        for (int i = 0; i < 6; i++) step(1'b1, -1);
        // constrained random: mostly back-to-back samples, some gaps
        for (int i = 0; i < 1500; i++) step(($urandom % 4) != 0, int'($urandom % 256) - 128);
        for (int i = 0; i < 12; i++) step(1'b0, 0);

        for (int d = 0; d < 4; d++)
            check(rd[d] == wr[d], "R1 all outputs seen", longint'(rd[d]), longint'(wr[d]));

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule